// File: doc/BRIEF.md
# ATA Software Reset Sequencer

This block runs a software reset on one ATA/CompactFlash task-file port from the host side and reports whether it passed. A one-cycle `start_i` pulse, together with a drive select, launches the sequence. The block selects the drive in the Device/Head register and raises the reset bit in Device Control with interrupts masked. It polls Alternate Status until the drive shows busy, then drops the reset bit while keeping interrupts masked. Next it polls until busy clears and then until the drive reports ready. Last, it reads back the six task-file registers that a drive loads after a reset and compares each one with the expected value.

All register traffic uses a simple synchronous bus. A read strobe returns data on `bus_rdata_i` in the cycle that follows the strobe. Each polling phase has its own limit, counted in pulses of `ms_tick_i`. If a phase runs out of time, the sequence stops and a code names that phase. A signature mismatch does not stop the sequence: all six reads still take place, and the failure is reported at the end.

Top module: `ata_srst_seq`

## Requirements
- R1: A start with `dev_sel_i` greater than 1 is rejected. `done_o` pulses in the next cycle with `success_o`=0 and `code_o`=5, and no bus strobe occurs during that run.
- R2: The first access of an accepted run is a write to address 6 (Device/Head). The data is 0x10 (bit 4 set) for drive 1 and 0x00 for drive 0.
- R3: The second access, in the very next cycle, is a write to address 0xE (Device Control) of 0x06. Bit 2 is the reset request and bit 1 masks interrupts.
- R4: The block then reads address 0xE (Alternate Status) until bit 7 (busy) reads 1. If `BSY1_MS` ticks pass without that, the run ends with `code_o`=1.
- R5: After busy is seen, the block writes 0x02 to address 0xE, which releases the reset and keeps interrupts masked.
- R6: The block polls address 0xE until bit 7 reads 0. If `BSY0_MS` ticks pass without that, the run ends with `code_o`=2.
- R7: The block polls address 0xE until bit 6 (ready) reads 1. If `DRDY_MS` ticks pass without that, the run ends with `code_o`=3.
- R8: The block reads address 7 and expects 0x50, address 2 and expects 0x01, address 3 and expects 0x01, and addresses 4, 5 and 6 and expects 0x00 from each. All six reads are always made. Any mismatch ends the run with `success_o`=0 and `code_o`=4.
- R9: A run in which no phase times out and all six values match ends with `success_o`=1 and `code_o`=0.
- R10: Each phase timer is cleared when its phase is entered and advances only on `ms_tick_i` pulses. A timed-out phase has therefore seen exactly its limit in ticks.
- R11: After reset, `done_o`, `success_o`, both strobes and `code_o` are all 0.
- R12: The block never asserts both strobes in the same cycle. A read strobe and `done_o` each last exactly one cycle.
- R13: A `start_i` that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dev_sel_i | input | SEL_W | Drive number; only 0 and 1 are valid |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| bus_addr_o | output | 4 | Register address; bit 3 selects the control block |
| bus_wdata_o | output | 8 | Write data |
| bus_wr_o | output | 1 | Write strobe, one cycle |
| bus_rd_o | output | 1 | Read strobe, one cycle |
| bus_rdata_i | input | 8 | Read data, valid the cycle after `bus_rd_o` |
| done_o | output | 1 | One-cycle completion pulse |
| success_o | output | 1 | Pass result, held until the next accepted start |
| code_o | output | 3 | 0 none, 1 busy-rise, 2 busy-fall, 3 ready, 4 signature, 5 bad drive |

## Verification
Some properties are checked on every cycle. Both strobes never appear together. A read strobe and the done pulse each last one cycle. The reset-request write always follows the drive-select write immediately. A rejected drive produces done with no bus traffic. A passing result always carries code 0. The phase timer never passes its limit and does not move without a tick.

Other behaviours can only be shown by the bench scenarios. One is which phase owns a timeout, and the exact number of ticks that phase consumed. Another is that all six signature reads still take place after an early mismatch. The bench also confirms that each fault leads to the right code, using a drive model whose busy and ready delays and corrupted register are swept.

// File: rtl/ata_srst_pkg.sv
package ata_srst_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int CODE_W = 3;
  localparam int SIG_N  = 6;
  localparam int IDX_W  = $clog2(SIG_N);

  localparam logic [ADDR_W-1:0] A_SCNT = 4'h2;
  localparam logic [ADDR_W-1:0] A_SNUM = 4'h3;
  localparam logic [ADDR_W-1:0] A_CYLL = 4'h4;
  localparam logic [ADDR_W-1:0] A_CYLH = 4'h5;
  localparam logic [ADDR_W-1:0] A_DH   = 4'h6;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h7;
  localparam logic [ADDR_W-1:0] A_CTL  = 4'hE;  // alt status on read, device control on write

  localparam int BIT_BSY  = 7;
  localparam int BIT_DRDY = 6;
  localparam int BIT_DEV  = 4;
  localparam int BIT_SRST = 2;
  localparam int BIT_NIEN = 1;

  localparam logic [DATA_W-1:0] CTL_SET = DATA_W'((1 << BIT_SRST) | (1 << BIT_NIEN));
  localparam logic [DATA_W-1:0] CTL_REL = DATA_W'(1 << BIT_NIEN);

  localparam logic [CODE_W-1:0] C_OK   = 3'd0;
  localparam logic [CODE_W-1:0] C_BSY1 = 3'd1;
  localparam logic [CODE_W-1:0] C_BSY0 = 3'd2;
  localparam logic [CODE_W-1:0] C_DRDY = 3'd3;
  localparam logic [CODE_W-1:0] C_SIG  = 3'd4;
  localparam logic [CODE_W-1:0] C_DEV  = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_WR_DH, S_WR_SET, S_B1_RD, S_B1_CHK, S_WR_REL,
    S_B0_RD, S_B0_CHK, S_RDY_RD, S_RDY_CHK, S_SIG_RD, S_SIG_CHK, S_DONE
  } st_e;
endpackage

// File: rtl/ata_srst_timer.sv
module ata_srst_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q <= limit_i);
  p_cnt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/ata_srst_sig.sv
module ata_srst_sig
  import ata_srst_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] exp_o
);
  always_comb begin
    unique case (idx_i)
      3'd0:    begin addr_o = A_STAT; exp_o = 8'h50; end
      3'd1:    begin addr_o = A_SCNT; exp_o = 8'h01; end
      3'd2:    begin addr_o = A_SNUM; exp_o = 8'h01; end
      3'd3:    begin addr_o = A_CYLL; exp_o = 8'h00; end
      3'd4:    begin addr_o = A_CYLH; exp_o = 8'h00; end
      3'd5:    begin addr_o = A_DH;   exp_o = 8'h00; end
      default: begin addr_o = A_STAT; exp_o = 8'h00; end
    endcase
  end
endmodule

// File: rtl/ata_srst_seq.sv
module ata_srst_seq
  import ata_srst_pkg::*;
#(
  parameter int BSY1_MS = 100,
  parameter int BSY0_MS = 1000,
  parameter int DRDY_MS = 1000,
  parameter int SEL_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  dev_sel_i,
  input  logic              ms_tick_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o,
  output logic              success_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int MAX_A  = (BSY1_MS > BSY0_MS) ? BSY1_MS : BSY0_MS;
  localparam int MAX_MS = (MAX_A > DRDY_MS) ? MAX_A : DRDY_MS;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  st_e               state_q;
  logic              dev_q, sig_bad_q, success_q;
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  sig_idx_q;
  logic [ADDR_W-1:0] sig_addr;
  logic [DATA_W-1:0] sig_exp;
  logic              tmr_clr, tmr_exp, timed, bsy, drdy, bad_now;
  logic [CNT_W-1:0]  tmr_limit;

  assign bsy     = bus_rdata_i[BIT_BSY];
  assign drdy    = bus_rdata_i[BIT_DRDY];
  assign bad_now = (bus_rdata_i != sig_exp);

  ata_srst_sig u_sig (
    .idx_i  (sig_idx_q),
    .addr_o (sig_addr),
    .exp_o  (sig_exp)
  );

  always_comb begin
    timed   = state_q inside {S_B1_RD, S_B1_CHK, S_B0_RD, S_B0_CHK, S_RDY_RD, S_RDY_CHK};
    tmr_clr = !timed || (state_q == S_B0_CHK && !bsy);
    unique case (state_q)
      S_B1_RD, S_B1_CHK:   tmr_limit = CNT_W'(BSY1_MS);
      S_B0_RD, S_B0_CHK:   tmr_limit = CNT_W'(BSY0_MS);
      S_RDY_RD, S_RDY_CHK: tmr_limit = CNT_W'(DRDY_MS);
      default:             tmr_limit = '0;
    endcase
  end

  ata_srst_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .tick_i    (ms_tick_i),
    .limit_i   (tmr_limit),
    .expired_o (tmr_exp)
  );

  always_comb begin
    bus_wr_o    = state_q inside {S_WR_DH, S_WR_SET, S_WR_REL};
    bus_rd_o    = state_q inside {S_B1_RD, S_B0_RD, S_RDY_RD, S_SIG_RD};
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      S_WR_DH:  begin bus_addr_o = A_DH;  bus_wdata_o = {{(DATA_W-1){1'b0}}, dev_q} << BIT_DEV; end
      S_WR_SET: begin bus_addr_o = A_CTL; bus_wdata_o = CTL_SET; end
      S_WR_REL: begin bus_addr_o = A_CTL; bus_wdata_o = CTL_REL; end
      S_B1_RD, S_B0_RD, S_RDY_RD: bus_addr_o = A_CTL;
      S_SIG_RD: bus_addr_o = sig_addr;
      default: ;
    endcase
  end

  assign done_o    = (state_q == S_DONE);
  assign success_o = success_q;
  assign code_o    = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      dev_q     <= 1'b0;
      sig_bad_q <= 1'b0;
      success_q <= 1'b0;
      code_q    <= C_OK;
      sig_idx_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          success_q <= 1'b0;
          if (dev_sel_i > SEL_W'(1)) begin
            code_q  <= C_DEV;
            state_q <= S_DONE;
          end else begin
            code_q    <= C_OK;
            dev_q     <= dev_sel_i[0];
            sig_bad_q <= 1'b0;
            state_q   <= S_WR_DH;
          end
        end
        S_WR_DH:  state_q <= S_WR_SET;
        S_WR_SET: state_q <= S_B1_RD;
        S_B1_RD:  state_q <= S_B1_CHK;
        S_B1_CHK:
          if (bsy)          state_q <= S_WR_REL;
          else if (tmr_exp) begin code_q <= C_BSY1; state_q <= S_DONE; end
          else              state_q <= S_B1_RD;
        S_WR_REL: state_q <= S_B0_RD;
        S_B0_RD:  state_q <= S_B0_CHK;
        S_B0_CHK:
          if (!bsy)         state_q <= S_RDY_RD;
          else if (tmr_exp) begin code_q <= C_BSY0; state_q <= S_DONE; end
          else              state_q <= S_B0_RD;
        S_RDY_RD: state_q <= S_RDY_CHK;
        S_RDY_CHK:
          if (drdy)         begin sig_idx_q <= '0; state_q <= S_SIG_RD; end
          else if (tmr_exp) begin code_q <= C_DRDY; state_q <= S_DONE; end
          else              state_q <= S_RDY_RD;
        S_SIG_RD: state_q <= S_SIG_CHK;
        S_SIG_CHK: begin
          sig_bad_q <= sig_bad_q | bad_now;
          if (sig_idx_q == IDX_W'(SIG_N - 1)) begin
            success_q <= !(sig_bad_q | bad_now);
            code_q    <= (sig_bad_q | bad_now) ? C_SIG : C_OK;
            state_q   <= S_DONE;
          end else begin
            sig_idx_q <= sig_idx_q + 1'b1;
            state_q   <= S_SIG_RD;
          end
        end
        S_DONE:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  p_single_access_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));
  p_rd_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |=> !bus_rd_o);
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_reject_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && dev_sel_i > SEL_W'(1))
      |=> (done_o && !bus_wr_o && !bus_rd_o && code_o == C_DEV));
  p_srst_after_dh_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && bus_addr_o == A_DH)
      |=> (bus_wr_o && bus_addr_o == A_CTL && bus_wdata_o == CTL_SET));
  p_pass_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && success_o) |-> code_o == C_OK);
endmodule

// File: tb/ata_srst_seq_tb.sv
`timescale 1ns/1ps
module ata_srst_seq_tb_top;
  localparam int B1 = 4, B0 = 6, DR = 5, NV = 255;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ms_tick = 1'b0, model_clr = 1'b0;
  logic [1:0] dev = '0;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic wr, rd, done, success;
  logic [2:0] code;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  ata_srst_seq #(.BSY1_MS(B1), .BSY0_MS(B0), .DRDY_MS(DR), .SEL_W(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_sel_i(dev), .ms_tick_i(ms_tick),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_wr_o(wr), .bus_rd_o(rd),
    .bus_rdata_i(rdata), .done_o(done), .success_o(success), .code_o(code));

  // drive model
  int d1, d2, d3, bad_idx;
  int n1, n2;
  bit srst_seen, rel_seen;
  always @(posedge clk) begin
    if (model_clr) begin
      n1 = 0; n2 = 0; srst_seen = 0; rel_seen = 0; rdata <= 8'h00;
    end else begin
      if (wr && addr == 4'hE) begin
        if (wdata[2]) begin srst_seen = 1; n1 = 0; end
        else begin rel_seen = 1; n2 = 0; end
      end
      if (rd) begin
        logic b, r;
        logic [7:0] v;
        b = 0; r = 0; v = 8'h00;
        case (addr)
          4'hE: begin
            if (rel_seen) begin
              b = (n2 < d2); r = !b && (d3 != NV) && (n2 >= d2 + d3); n2++;
            end else if (srst_seen) begin
              b = (d1 != NV) && (n1 >= d1); n1++;
            end
            v = {b, r, 6'b0};
          end
          4'h7: v = 8'h50 ^ ((bad_idx == 0) ? 8'h01 : 8'h00);
          4'h2, 4'h3: v = 8'h01 ^ ((bad_idx == int'(addr) - 1) ? 8'h01 : 8'h00);
          4'h4, 4'h5, 4'h6: v = 8'h00 ^ ((bad_idx == int'(addr) - 1) ? 8'h01 : 8'h00);
          default: v = 8'h00;
        endcase
        rdata <= v;
      end
    end
  end

  // millisecond tick, one pulse every 5 clocks
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      div = (div == 4) ? 0 : div + 1;
      ms_tick = (div == 4);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int dv, input int a1, input int a2, input int a3, input int bi, input bit restart);
    int wa[8], wd[8];
    int nw = 0, nrd = 0, nsig = 0, tk = 0, cyc = 0;
    bit arm = 0, both = 0, seen = 0, rd_long = 0, prev_rd = 0;
    int ecode, enw, esig, ecnt;
    @(negedge clk);
    d1 = a1; d2 = a2; d3 = a3; bad_idx = bi; model_clr = 1;
    @(negedge clk);
    model_clr = 0; start = 1; dev = 2'(dv);
    while (!seen && cyc < 3000) begin
      @(negedge clk);
      if (cyc == 0) start = 0;
      if (restart && cyc == 4) begin start = 1; dev = 2'd3; end
      if (restart && cyc == 5) start = 0;
      if (wr && rd) both = 1;
      if (rd && prev_rd) rd_long = 1;
      prev_rd = rd;
      if (rd) begin nrd++; if (addr >= 4'h2 && addr <= 4'h7) nsig++; end
      if (wr) begin
        if (nw < 8) begin wa[nw] = int'(addr); wd[nw] = int'(wdata); end
        nw++;
        if (addr == 4'hE) begin arm = 1; tk = 0; end
      end else if (arm && !done && ms_tick) tk++;
      if (done) seen = 1;
      cyc++;
    end
    if (dv > 1) begin ecode = 5; enw = 0; esig = 0; end
    else begin
      ecode = (a1 == NV) ? 1 : (a2 == NV) ? 2 : (a3 == NV) ? 3 : (bi < 6) ? 4 : 0;
      enw = (a1 == NV) ? 2 : 3;
      esig = (ecode == 0 || ecode == 4) ? 6 : 0;
    end
    chk(seen, "R12 done seen", int'(seen), 1);
    case (ecode)
      0: chk(code == 3'd0, "R9 code", int'(code), 0);
      1: chk(code == 3'd1, "R4 code", int'(code), 1);
      2: chk(code == 3'd2, "R6 code", int'(code), 2);
      3: chk(code == 3'd3, "R7 code", int'(code), 3);
      4: chk(code == 3'd4, "R8 code", int'(code), 4);
      default: chk(code == 3'd5, "R1 code", int'(code), 5);
    endcase
    chk(success == (ecode == 0), "R9 success", int'(success), int'(ecode == 0));
    chk(nw == enw, "R1 R5 write count", nw, enw);
    chk(nsig == esig, "R8 signature reads", nsig, esig);
    chk(!both && !rd_long, "R12 single access", int'(both) + int'(rd_long), 0);
    if (dv > 1) chk(nrd == 0, "R1 no reads", nrd, 0);
    else begin
      chk(wa[0] == 6 && wd[0] == (dv == 1 ? 8'h10 : 8'h00), "R2 dev/head write", wd[0], dv == 1 ? 16 : 0);
      chk(wa[1] == 14 && wd[1] == 8'h06, "R3 srst write", wd[1], 6);
      if (enw == 3) chk(wa[2] == 14 && wd[2] == 8'h02, "R5 release write", wd[2], 2);
      if (ecode == 1 || ecode == 2) begin
        ecnt = (ecode == 1) ? B1 : B0;
        chk(tk == ecnt, "R10 ticks in phase", tk, ecnt);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !wr && !rd && !success && code == 3'd0, "R11 reset state",
        int'(done) + int'(wr) + int'(rd) + int'(success) + int'(code), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int dv = 0; dv < 4; dv++) begin
      for (int i1 = 0; i1 < 3; i1++)
        for (int i2 = 0; i2 < 3; i2++)
          for (int i3 = 0; i3 < 3; i3++)
            for (int bi = 0; bi <= 6; bi++) begin
              if (dv > 1 && (i1 + i2 + i3 + bi) != 6) continue;
              run(dv, (i1 == 2) ? NV : i1 * 2, (i2 == 2) ? NV : i2 * 3,
                  (i3 == 2) ? NV : i3, bi, 1'b0);
            end
    end
    run(0, 1, 2, 1, 6, 1'b1);  // R13: start mid-run ignored
    chk(code == 3'd0 && success, "R13 restart ignored", int'(code), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule